// File: doc/BRIEF.md
# Page Write Commit and Timer Engine

This block handles one non-volatile write transaction in a serial memory controller. It can be either an array write or a status-byte write. Once a write-enabled start is taken, it loads the start address and places each incoming data byte in a page buffer. The buffer is one page of `PAGE` bytes, and each slot has its own valid flag. The write pointer moves through the low address bits and wraps inside the page, so a byte written later overwrites an earlier byte at the same slot.

The transaction ends with the chip-select rising edge. The commit goes ahead only when that edge falls exactly on a byte boundary. A status write must also have carried exactly one byte. If the commit goes ahead, the engine raises its busy flag and holds it for a fixed self-timed interval of `WAIT_CYC` clocks. It then walks the page one slot per clock. For each received slot it asks the protect logic about that byte's address, and it writes the slot to the array only if the address is not protected. On the last slot it pulses the write-enable clear. Any start, byte or chip-select event that arrives during the busy interval is dropped.

Top module: `pgwr_engine`

## Requirements
- R1: A start request (`start_arr` or `start_stat`) is taken only in the idle state and only while `wel` is 1. If `wel` is 0, the start is ignored and a later `cs_rise` raises no busy and writes nothing.
- R2: Array data bytes go to address `{page of start_addr, offset}`. The offset begins at the low log2(`PAGE`) bits of `start_addr` and increases by one per byte, wrapping from `PAGE-1` to 0 within the same page. A later byte written to the same offset replaces the earlier one.
- R3: `bit_cnt` gives the number of bits of the current partial byte already received; 0 means the transfer sits on a byte boundary. The commit is accepted only when `cs_rise` arrives with `bit_cnt` = 0 and at least one byte received. Otherwise the transaction is cancelled: busy stays low and nothing is written.
- R4: A status write is accepted only if exactly one byte was received before a boundary-aligned `cs_rise`. That byte appears on `st_wdata` with a single-cycle `st_we` during the commit phase.
- R5: After an accepted `cs_rise` clock edge, `busy` is 1 for exactly `WAIT_CYC + PAGE` consecutive cycles and then returns to 0.
- R6: `arr_we` pulses only during the last `PAGE` busy cycles. It pulses only for slots that received a byte, and never for an address that `prot_hit` (1 = protected) marks as protected.
- R7: `wel_clr` pulses for one cycle in the final busy cycle of every accepted transaction, and busy is 0 in the cycle after.
- R8: Starts, data bytes and `cs_rise` that arrive while busy is 1 are ignored. The running cycle keeps its length and its data, and no other address changes.
- R9: After reset, `busy`, `arr_we`, `st_we` and `wel_clr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wel | input | 1 | Write-enable latch state |
| start_arr | input | 1 | Begin an array write transaction |
| start_stat | input | 1 | Begin a status write transaction |
| start_addr | input | ADDR_W | Start address of an array write |
| byte_vld | input | 1 | A full data byte is available |
| byte_data | input | 8 | Received data byte |
| bit_cnt | input | 3 | Bits of the current partial byte received (0 = boundary) |
| cs_rise | input | 1 | Chip-select rising edge event |
| prot_addr | output | ADDR_W | Address queried for protection |
| prot_hit | input | 1 | 1 when `prot_addr` is protected |
| busy | output | 1 | Write in progress |
| arr_we | output | 1 | Array byte write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | 8 | Array write data |
| st_we | output | 1 | Status byte write strobe |
| st_wdata | output | 8 | Status byte value |
| wel_clr | output | 1 | Clear the write-enable latch |

## Verification
Some rules are checked by the assertions on every cycle. Array writes must happen only while busy and never to a protected address. Busy may rise only right after a boundary-aligned chip-select edge. The busy window must last exactly `WAIT_CYC + PAGE` cycles. The latch clear and the status strobe must sit where they belong in the commit. Other behaviours can only be shown by the bench scenarios, because they concern contents rather than timing. These are page wrap with overwrite, the dropping of unreceived slots, the status-byte count rule, the refusal of starts without write enable, and the proof that traffic injected during busy leaves the memory untouched.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_FILL,
    ENG_WAIT,
    ENG_COPY
  } eng_state_t;

  // Splice an in-page offset into the page field of a full address.
  function automatic logic [15:0] join_addr(input logic [15:0] base,
                                            input logic [15:0] ofs,
                                            input int          ofs_w);
    logic [15:0] mask;
    mask = (16'h1 << ofs_w) - 16'h1;
    return (base & ~mask) | (ofs & mask);
  endfunction

  // Decide whether a finished transfer may be committed.
  function automatic logic commit_ok(input logic       aligned,
                                     input logic       any_byte,
                                     input logic       many_bytes,
                                     input logic       is_status);
    return aligned && any_byte && !(is_status && many_bytes);
  endfunction

endpackage

// File: rtl/pgwr_fill.sv
module pgwr_fill #(
  parameter int PAGE  = 32,
  parameter int OFS_W = $clog2(PAGE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [OFS_W-1:0] load_ofs,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic [OFS_W-1:0] rd_slot,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             any_byte,
  output logic             many_bytes
);

  logic [7:0]       slot_mem [PAGE];
  logic [PAGE-1:0]  slot_vld;
  logic [OFS_W-1:0] wptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_vld   <= '0;
      wptr       <= '0;
      any_byte   <= 1'b0;
      many_bytes <= 1'b0;
    end else if (clr) begin
      slot_vld   <= '0;
      wptr       <= load_ofs;
      any_byte   <= 1'b0;
      many_bytes <= 1'b0;
    end else if (wr_en) begin
      slot_vld[wptr] <= 1'b1;
      wptr           <= wptr + 1'b1;
      many_bytes     <= any_byte;
      any_byte       <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !clr) slot_mem[wptr] <= wr_data;
  end

  assign rd_data  = slot_mem[rd_slot];
  assign rd_valid = slot_vld[rd_slot];

endmodule

// File: rtl/pgwr_timer.sv
module pgwr_timer #(
  parameter int WAIT_CYC = 50000,
  parameter int TW       = (WAIT_CYC > 2) ? $clog2(WAIT_CYC) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic done
);

  logic [TW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    remain <= '0;
    else if (load)                 remain <= TW'(WAIT_CYC - 1);
    else if (run && remain != '0)  remain <= remain - 1'b1;
  end

  assign done = (remain == '0);

endmodule

// File: rtl/pgwr_engine.sv
module pgwr_engine
  import pgwr_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int PAGE     = 32,
  parameter int WAIT_CYC = 50000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wel,
  input  logic              start_arr,
  input  logic              start_stat,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              byte_vld,
  input  logic [7:0]        byte_data,
  input  logic [2:0]        bit_cnt,
  input  logic              cs_rise,
  output logic [ADDR_W-1:0] prot_addr,
  input  logic              prot_hit,
  output logic              busy,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [7:0]        arr_wdata,
  output logic              st_we,
  output logic [7:0]        st_wdata,
  output logic              wel_clr
);

  localparam int OFS_W = $clog2(PAGE);
  localparam logic [OFS_W-1:0] LAST_SLOT = OFS_W'(PAGE - 1);

  eng_state_t        state;
  logic              is_stat;
  logic [ADDR_W-1:0] page_base;
  logic [OFS_W-1:0]  slot;

  // Named internal events
  logic take_start;
  logic accept_evt;
  logic cancel_evt;
  logic fill_wr;
  logic in_copy;
  logic last_slot;
  logic tmr_done;

  logic [7:0] buf_data;
  logic       buf_valid;
  logic       any_byte;
  logic       many_bytes;

  assign take_start = (state == ENG_IDLE) && wel && (start_arr || start_stat);
  assign fill_wr    = (state == ENG_FILL) && byte_vld;
  assign accept_evt = (state == ENG_FILL) && cs_rise &&
                      commit_ok(bit_cnt == 3'd0, any_byte, many_bytes, is_stat);
  assign cancel_evt = (state == ENG_FILL) && cs_rise && !accept_evt;
  assign in_copy    = (state == ENG_COPY);
  assign last_slot  = (slot == LAST_SLOT);

  pgwr_fill #(.PAGE(PAGE), .OFS_W(OFS_W)) u_fill (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (take_start),
    .load_ofs   (start_arr ? start_addr[OFS_W-1:0] : '0),
    .wr_en      (fill_wr),
    .wr_data    (byte_data),
    .rd_slot    (slot),
    .rd_data    (buf_data),
    .rd_valid   (buf_valid),
    .any_byte   (any_byte),
    .many_bytes (many_bytes)
  );

  pgwr_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept_evt),
    .run   (state == ENG_WAIT),
    .done  (tmr_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ENG_IDLE;
      is_stat   <= 1'b0;
      page_base <= '0;
      slot      <= '0;
    end else begin
      unique case (state)
        ENG_IDLE: if (take_start) begin
          state     <= ENG_FILL;
          is_stat   <= !start_arr;
          page_base <= start_arr ? start_addr : '0;
        end
        ENG_FILL: begin
          if (accept_evt)      state <= ENG_WAIT;
          else if (cancel_evt) state <= ENG_IDLE;
        end
        ENG_WAIT: if (tmr_done) begin
          state <= ENG_COPY;
          slot  <= '0;
        end
        ENG_COPY: begin
          slot <= slot + 1'b1;
          if (last_slot) state <= ENG_IDLE;
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

  assign prot_addr = ADDR_W'(join_addr(16'(page_base), 16'(slot), OFS_W));
  assign busy      = (state == ENG_WAIT) || in_copy;
  assign arr_we    = in_copy && !is_stat && buf_valid && !prot_hit;
  assign arr_addr  = prot_addr;
  assign arr_wdata = buf_data;
  assign st_we     = in_copy && is_stat && (slot == '0);
  assign st_wdata  = buf_data;
  assign wel_clr   = in_copy && last_slot;

endmodule

// File: rtl/pgwr_chk.sv
module pgwr_chk #(
  parameter int PAGE     = 32,
  parameter int WAIT_CYC = 50000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       cs_rise,
  input logic [2:0] bit_cnt,
  input logic       arr_we,
  input logic       prot_hit,
  input logic       st_we,
  input logic       wel_clr,
  input logic       accept_evt
);

  localparam int TOTAL = WAIT_CYC + PAGE;

  int unsigned busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= 0;
    else if (busy) busy_len <= busy_len + 1;
    else           busy_len <= 0;
  end

  AST_WRITE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy); // R6
  AST_NO_PROT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> !prot_hit); // R6
  AST_BUSY_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(cs_rise) && $past(bit_cnt) == 3'd0 && $past(accept_evt))); // R3
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(busy)) |-> (busy_len == TOTAL)); // R5
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_len < TOTAL)); // R5
  AST_WEL_CLR_END: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |=> !busy); // R7
  AST_WEL_CLR_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |-> busy); // R7
  AST_STATUS_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |-> (busy && !arr_we)); // R4
  AST_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !accept_evt); // R8

endmodule

bind pgwr_engine pgwr_chk #(.PAGE(PAGE), .WAIT_CYC(WAIT_CYC)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .cs_rise    (cs_rise),
  .bit_cnt    (bit_cnt),
  .arr_we     (arr_we),
  .prot_hit   (prot_hit),
  .st_we      (st_we),
  .wel_clr    (wel_clr),
  .accept_evt (accept_evt)
);

// File: tb/pgwr_engine_tb_top.sv
module pgwr_engine_tb_top;

  localparam int ADDR_W   = 13;
  localparam int PAGE     = 32;
  localparam int WAIT_CYC = 40;
  localparam int MEMSZ    = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wel = 1'b0;
  logic              start_arr = 1'b0;
  logic              start_stat = 1'b0;
  logic [ADDR_W-1:0] start_addr = '0;
  logic              byte_vld = 1'b0;
  logic [7:0]        byte_data = '0;
  logic [2:0]        bit_cnt = '0;
  logic              cs_rise = 1'b0;
  logic [ADDR_W-1:0] prot_addr;
  logic              prot_hit;
  logic              busy;
  logic              arr_we;
  logic [ADDR_W-1:0] arr_addr;
  logic [7:0]        arr_wdata;
  logic              st_we;
  logic [7:0]        st_wdata;
  logic              wel_clr;

  int prot_lo = MEMSZ;
  int checks = 0;
  int errors = 0;
  int clr_cnt = 0;
  int st_cnt = 0;
  logic [7:0] st_last = '0;
  logic [7:0] mem     [MEMSZ];
  logic [7:0] exp_mem [MEMSZ];

  always #2 clk = ~clk;

  assign prot_hit = (int'(prot_addr) >= prot_lo);

  pgwr_engine #(.ADDR_W(ADDR_W), .PAGE(PAGE), .WAIT_CYC(WAIT_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .wel(wel), .start_arr(start_arr),
    .start_stat(start_stat), .start_addr(start_addr), .byte_vld(byte_vld),
    .byte_data(byte_data), .bit_cnt(bit_cnt), .cs_rise(cs_rise),
    .prot_addr(prot_addr), .prot_hit(prot_hit), .busy(busy), .arr_we(arr_we),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata), .st_we(st_we),
    .st_wdata(st_wdata), .wel_clr(wel_clr)
  );

  always @(posedge clk) begin
    if (arr_we) mem[arr_addr] <= arr_wdata;
    if (wel_clr) clr_cnt <= clr_cnt + 1;
    if (st_we) begin
      st_cnt  <= st_cnt + 1;
      st_last <= st_wdata;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // Bench-side address rule: base of page plus offset modulo page size.
  function automatic int wrap_addr(input int start, input int idx);
    int base;
    base = start - (start % PAGE);
    return base + ((start % PAGE) + idx) % PAGE;
  endfunction

  function automatic bit will_commit(input bit stat, input int n, input int part, input bit w);
    if (!w || part != 0 || n < 1) return 1'b0;
    if (stat && n != 1) return 1'b0;
    return 1'b1;
  endfunction

  task automatic page_compare(input int start, input string req);
    int base;
    int bad;
    int bad_a;
    base = start - (start % PAGE);
    bad = 0;
    bad_a = 0;
    for (int i = 0; i < PAGE; i++)
      if (mem[base + i] !== exp_mem[base + i]) begin
        bad++;
        bad_a = base + i;
      end
    check(bad == 0, req, (bad == 0) ? 0 : int'(mem[bad_a]),
          (bad == 0) ? 0 : int'(exp_mem[bad_a]));
  endtask

  // One transaction; inject=1 pushes foreign traffic into the busy window.
  task automatic run_op(input bit stat, input int addr, input int n,
                        input int part, input bit w, input bit inject,
                        input int inj_addr);
    logic [7:0] dat [64];
    int blen;
    int clr0;
    int st0;
    bit acc;
    acc  = will_commit(stat, n, part, w);
    clr0 = clr_cnt;
    st0  = st_cnt;
    @(negedge clk);
    wel        = w;
    start_arr  = !stat;
    start_stat = stat;
    start_addr = ADDR_W'(addr);
    @(negedge clk);
    start_arr  = 1'b0;
    start_stat = 1'b0;
    for (int i = 0; i < n; i++) begin
      dat[i]    = 8'($urandom);
      byte_vld  = 1'b1;
      byte_data = dat[i];
      @(negedge clk);
    end
    byte_vld = 1'b0;
    bit_cnt  = 3'(part);
    cs_rise  = 1'b1;
    @(negedge clk);
    cs_rise = 1'b0;
    bit_cnt = 3'd0;
    blen = 0;
    while (busy && blen < 1000) begin
      blen++;
      if (inject && blen == 5) begin
        start_arr  = 1'b1;
        start_addr = ADDR_W'(inj_addr);
        byte_vld   = 1'b1;
        byte_data  = 8'h5A;
        cs_rise    = 1'b1;
      end else begin
        start_arr = 1'b0;
        byte_vld  = 1'b0;
        cs_rise   = 1'b0;
      end
      @(negedge clk);
    end
    start_arr = 1'b0;
    byte_vld  = 1'b0;
    cs_rise   = 1'b0;
    wel       = 1'b0;
    repeat (2) @(negedge clk);
    if (acc && !stat)
      for (int i = 0; i < n; i++)
        if (wrap_addr(addr, i) < prot_lo) exp_mem[wrap_addr(addr, i)] = dat[i];
    // R5 / R3 / R1: busy window length
    check(blen == (acc ? WAIT_CYC + PAGE : 0), "R5 busy length", blen,
          acc ? WAIT_CYC + PAGE : 0);
    // R7: one latch clear per accepted commit
    check(clr_cnt - clr0 == (acc ? 1 : 0), "R7 wel_clr count", clr_cnt - clr0, acc ? 1 : 0);
    if (stat) begin
      check(st_cnt - st0 == (acc ? 1 : 0), "R4 status strobe count", st_cnt - st0, acc ? 1 : 0);
      if (acc) check(st_last == dat[0], "R4 status value", st_last, dat[0]);
    end else begin
      page_compare(addr, "R2 R6 page contents");
    end
    if (inject) page_compare(inj_addr, "R8 injected page untouched");
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    for (int i = 0; i < MEMSZ; i++) begin
      mem[i]     = 8'hFF;
      exp_mem[i] = 8'hFF;
    end
    repeat (3) @(negedge clk);
    // R9: reset state
    check(!busy && !arr_we && !st_we && !wel_clr, "R9 reset outputs",
          {busy, arr_we, st_we, wel_clr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy, "R9 idle after reset", busy, 0);

    run_op(1'b0, 16'h0040, 4, 0, 1'b0, 1'b0, 0);          // R1 no write enable
    run_op(1'b0, 16'h0085, 32, 0, 1'b1, 1'b0, 0);         // R2 full page from offset 5
    run_op(1'b0, 16'h00DE, 40, 0, 1'b1, 1'b0, 0);         // R2 wrap and overwrite
    run_op(1'b0, 16'h0100, 3, 3, 1'b1, 1'b0, 0);          // R3 partial byte cancels
    run_op(1'b0, 16'h0120, 0, 0, 1'b1, 1'b0, 0);          // R3 no data cancels
    run_op(1'b0, 16'h0140, 1, 0, 1'b1, 1'b0, 0);          // R3 single byte commits
    prot_lo = 16'h0170;
    run_op(1'b0, 16'h0168, 20, 0, 1'b1, 1'b0, 0);         // R6 protected half dropped
    prot_lo = MEMSZ;
    run_op(1'b1, 0, 1, 0, 1'b1, 1'b0, 0);                 // R4 status single byte
    run_op(1'b1, 0, 2, 0, 1'b1, 1'b0, 0);                 // R4 two bytes cancel
    run_op(1'b1, 0, 1, 5, 1'b1, 1'b0, 0);                 // R4 partial cancels
    run_op(1'b0, 16'h0200, 8, 0, 1'b1, 1'b1, 16'h0300);   // R8 traffic while busy

    for (int k = 0; k < 25; k++) begin
      int a;
      int n;
      int part;
      a    = int'($urandom_range(MEMSZ - 1, 0));
      n    = int'($urandom_range(40, 0));
      part = ($urandom_range(9, 0) == 0) ? int'($urandom_range(7, 1)) : 0;
      prot_lo = ($urandom_range(3, 0) == 0) ? int'($urandom_range(MEMSZ - 1, 0)) : MEMSZ;
      run_op($urandom_range(5, 0) == 0, a, n, part, $urandom_range(7, 0) != 0, 1'b0, 0);
    end
    prot_lo = MEMSZ;

    begin
      int bad;
      bad = 0;
      for (int i = 0; i < MEMSZ; i++) if (mem[i] !== exp_mem[i]) bad++;
      check(bad == 0, "R2 R6 R8 whole array", bad, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule